// File: doc/BRIEF.md
# Keypad scan controller

This block walks a key matrix one column at a time. While a column is pulled low, it waits for the row lines to settle and then samples up to six row inputs. A row with a pressed key reads low because the rows are pulled up. When a row pattern is not empty, the block samples again after a debounce wait. It accepts the key only if the second sample gives the same pattern. It then records the row pattern and the column index. After the last column it waits a between-scan interval and starts over from the first column.

Every wait is a whole number of 2 ms steps. The step is counted in ticks of a divided clock, and the clock divider is a configuration input. Four sticky event flags report the results: no key, key, scan complete and wake-up. Each flag has its own enable, and the enabled flags are ORed into one interrupt line. Scanning is controlled by single-cycle start and stop pulses, by an auto-start on enable, by a block enable and by a software reset. All configuration arrives on plain input ports.

Top module: `kpd_scan_ctrl`

## Requirements
- R1: A tick occurs every `clkdiv_i`+1 clocks. The settle phase, the debounce phase and the between-scan gap each last 2×(code+1) ticks, so a phase is 2×(code+1)×(`clkdiv_i`+1) clocks long, counted from the edge that enters it.
- R2: The row-count code gives the number of rows. Codes 2 to 5 select 3 to 6 rows, and codes 0 and 1 act as 3 rows. Rows at or above that count are ignored.
- R3: `cols_n_o` is active low. Exactly one bit, the current column, is low during the settle and debounce phases, and all bits are high while idle or in the gap. Columns are visited in order from 0 to NCOLS-1.
- R4: If the settle sample has a nonzero masked pattern (bit set = row low), the block debounces. It accepts a key only if the debounce sample equals that pattern. `row_st_o` and `col_st_o` then take the pattern and the column index.
- R5: A `start_i` pulse while idle begins a scan at column 0. A `stop_i` pulse returns the block to idle on the next edge, and stop wins over start. `running_o` is high exactly while the block is not idle.
- R6: While `en_i` is low, all core state and all flags are held at their reset values. If `autostart_i` is high, the first cycle of `en_i` high starts a scan. If `autostart_i` is low, the block stays idle until `start_i`.
- R7: In single-press mode (`single_i`=1), the key flag does not set again after it has been set until a complete scan has found no key.
- R8: In multi-press mode, every accepted key sets the key flag, even while the key is still held.
- R9: At the end of the last column, the scan-complete flag (bit 2) sets. If no key was accepted in that scan, the no-key flag (bit 0) also sets. `nokey_st_o` shows whether the scan that just finished found no key.
- R10: While idle and enabled, any row inside the row count that reads low sets the wake-up flag (bit 3).
- R11: The flags are `flags_o` = {wake, scan-complete, key, no-key}, and they are sticky. A one in `flag_clr_i` clears a flag, but a set event in the same cycle wins. `irq_o` is the OR of `flags_o & ie_i`.
- R12: A `swrst_i` pulse clears all flags, status and scan state on its edge. `resetting_o` is high for the one cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| swrst_i | input | 1 | Software reset pulse |
| start_i | input | 1 | Start scanning pulse |
| stop_i | input | 1 | Stop scanning pulse |
| autostart_i | input | 1 | Start automatically when enabled |
| single_i | input | 1 | Single-press mode select |
| clkdiv_i | input | 18 | Tick divider, period = value+1 clocks |
| settle_code_i | input | 4 | Row settle delay code |
| deb_code_i | input | 4 | Debounce delay code |
| gap_code_i | input | 4 | Between-scan delay code |
| nrows_code_i | input | 3 | Row count code |
| ie_i | input | 4 | Flag interrupt enables |
| flag_clr_i | input | 4 | Write-one-to-clear strobes |
| rows_i | input | 6 | Row inputs, low = pressed |
| cols_n_o | output | NCOLS | Column drives, active low |
| running_o | output | 1 | Scan in progress |
| resetting_o | output | 1 | Software reset busy |
| row_st_o | output | 6 | Row pattern of last accepted key |
| col_st_o | output | 3 | Column of last accepted key |
| nokey_st_o | output | 1 | Last finished scan found no key |
| flags_o | output | 4 | Sticky event flags |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two things can land on the same flag in one cycle: a set event and a clear strobe. The bench holds a row low while the block is idle, so the wake-up event repeats every cycle, and pulses the clear for that flag during the hold. The flag must stay set, and it must drop only once the row is released. A second collision happens when the debounce on the last column ends. The key acceptance and the end-of-scan decision then fall in the same cycle, and the no-key flag must stay clear. The bench's cycle model checks that the no-key flag does not set on that cycle.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int ROWS_MAX = 6;
  localparam int FL_NOKEY = 0;
  localparam int FL_KEY   = 1;
  localparam int FL_SCAN  = 2;
  localparam int FL_WAKE  = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_DEBNC, ST_GAP} kpd_state_e;

  // last tick index of a phase: 2*(code+1) ticks -> 0 .. 2*code+1
  function automatic logic [4:0] last_tick(input logic [3:0] code);
    return {code, 1'b1};
  endfunction

  // rows in use; codes below 2 fall back to three rows
  function automatic logic [ROWS_MAX-1:0] row_mask(input logic [2:0] code);
    case (code)
      3'd3:    return 6'b001111;
      3'd4:    return 6'b011111;
      3'd5, 3'd6, 3'd7: return 6'b111111;
      default: return 6'b000111;
    endcase
  endfunction

  // pressed rows, active high, limited to the rows in use
  function automatic logic [ROWS_MAX-1:0] row_hits(input logic [ROWS_MAX-1:0] rows,
                                                   input logic [2:0] code);
    return ~rows & row_mask(code);
  endfunction
endpackage

// File: rtl/kpd_timer.sv
module kpd_timer
  import kpd_pkg::*;
#(
  parameter int DIVW = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_i,
  input  logic [DIVW-1:0] div_i,
  input  logic [3:0]      code_i,
  output logic            done_o
);
  logic [DIVW-1:0] div_cnt;
  logic [4:0]      tick_cnt;
  logic            tick;

  assign tick   = (div_cnt == div_i);
  assign done_o = tick && (tick_cnt == last_tick(code_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      tick_cnt <= '0;
    end else if (hold_i || done_o) begin
      div_cnt  <= '0;
      tick_cnt <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) tick_cnt <= tick_cnt + 1'b1;
    end
  end

  // R1
  no_double_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/kpd_engine.sv
module kpd_engine
  import kpd_pkg::*;
#(
  parameter int NCOLS = 8,
  parameter int CW    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                phase_done_i,
  input  logic [ROWS_MAX-1:0] rows_i,
  input  logic [2:0]          nrows_code_i,
  output logic [NCOLS-1:0]    cols_n_o,
  output kpd_state_e          state_o,
  output logic                evt_key_o,
  output logic                evt_scan_o,
  output logic                evt_nokey_o,
  output logic                row_hit_o,
  output logic [ROWS_MAX-1:0] row_st_o,
  output logic [2:0]          col_st_o,
  output logic                nokey_st_o
);
  kpd_state_e          state_q, state_d;
  logic [CW-1:0]       col_q, col_d;
  logic [ROWS_MAX-1:0] pat_q, pat_d, hits;
  logic                kf_q, kf_d, advance, last_col, drive;

  assign hits      = row_hits(rows_i, nrows_code_i);
  assign row_hit_o = |hits;
  assign last_col  = (col_q == CW'(NCOLS - 1));
  assign drive     = (state_q == ST_SETTLE) || (state_q == ST_DEBNC);
  assign state_o   = state_q;

  always_comb begin
    for (int c = 0; c < NCOLS; c++) cols_n_o[c] = !(drive && (col_q == CW'(c)));
  end

  always_comb begin
    state_d     = state_q;
    col_d       = col_q;
    pat_d       = pat_q;
    kf_d        = kf_q;
    advance     = 1'b0;
    evt_key_o   = 1'b0;
    evt_scan_o  = 1'b0;
    evt_nokey_o = 1'b0;
    if (stop_i) begin
      state_d = ST_IDLE;
      col_d   = '0;
      kf_d    = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_d = ST_SETTLE;
          col_d   = '0;
        end
        ST_SETTLE: if (phase_done_i) begin
          if (|hits) begin
            pat_d   = hits;
            state_d = ST_DEBNC;
          end else advance = 1'b1;
        end
        ST_DEBNC: if (phase_done_i) begin
          if (hits == pat_q) begin
            evt_key_o = 1'b1;
            kf_d      = 1'b1;
          end
          advance = 1'b1;
        end
        default: if (phase_done_i) begin
          state_d = ST_SETTLE;
          col_d   = '0;
          kf_d    = 1'b0;
        end
      endcase
      if (advance) begin
        if (last_col) begin
          evt_scan_o  = 1'b1;
          evt_nokey_o = !(kf_q || evt_key_o);
          state_d     = ST_GAP;
        end else begin
          col_d   = col_q + 1'b1;
          state_d = ST_SETTLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; col_q <= '0; pat_q <= '0; kf_q <= 1'b0;
      row_st_o <= '0; col_st_o <= '0; nokey_st_o <= 1'b0;
    end else if (clr_i) begin
      state_q <= ST_IDLE; col_q <= '0; pat_q <= '0; kf_q <= 1'b0;
      row_st_o <= '0; col_st_o <= '0; nokey_st_o <= 1'b0;
    end else begin
      state_q <= state_d;
      col_q   <= col_d;
      pat_q   <= pat_d;
      kf_q    <= kf_d;
      if (evt_key_o) begin
        row_st_o <= hits;
        col_st_o <= 3'(col_q);
      end
      if (evt_scan_o) nokey_st_o <= evt_nokey_o;
    end
  end

  // R3
  one_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cols_n_o));
  // R3
  idle_cols_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (&cols_n_o));
  // R1
  phase_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_SETTLE && state_q != ST_SETTLE && !$past(clr_i) && !$past(stop_i))
      |-> $past(phase_done_i));
  // R4
  key_row_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    evt_key_o |=> (row_st_o != '0));
endmodule

// File: rtl/kpd_flags.sv
module kpd_flags
  import kpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_core_i,
  input  logic       single_i,
  input  logic [3:0] ev_i,
  input  logic [3:0] w1c_i,
  input  logic [3:0] ie_i,
  output logic [3:0] flags_o,
  output logic       irq_o
);
  logic [3:0] set_v;
  logic       armed_q;

  always_comb begin
    set_v         = ev_i;
    set_v[FL_KEY] = ev_i[FL_KEY] && (!single_i || armed_q);
  end

  assign irq_o = |(flags_o & ie_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_o <= '0;
      armed_q <= 1'b1;
    end else if (clr_core_i) begin
      flags_o <= '0;
      armed_q <= 1'b1;
    end else begin
      flags_o <= (flags_o & ~w1c_i) | set_v;
      if (set_v[FL_KEY])        armed_q <= 1'b0;
      else if (ev_i[FL_NOKEY])  armed_q <= 1'b1;
    end
  end

  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_core_i |=> ((flags_o & $past(flags_o & ~w1c_i)) == $past(flags_o & ~w1c_i)));
endmodule

// File: rtl/kpd_scan_ctrl.sv
module kpd_scan_ctrl
  import kpd_pkg::*;
#(
  parameter int NCOLS = 8,
  parameter int DIVW  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             swrst_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             autostart_i,
  input  logic             single_i,
  input  logic [DIVW-1:0]  clkdiv_i,
  input  logic [3:0]       settle_code_i,
  input  logic [3:0]       deb_code_i,
  input  logic [3:0]       gap_code_i,
  input  logic [2:0]       nrows_code_i,
  input  logic [3:0]       ie_i,
  input  logic [3:0]       flag_clr_i,
  input  logic [5:0]       rows_i,
  output logic [NCOLS-1:0] cols_n_o,
  output logic             running_o,
  output logic             resetting_o,
  output logic [5:0]       row_st_o,
  output logic [2:0]       col_st_o,
  output logic             nokey_st_o,
  output logic [3:0]       flags_o,
  output logic             irq_o
);
  localparam int CW = (NCOLS > 1) ? $clog2(NCOLS) : 1;

  kpd_state_e state;
  logic       en_q, core_clr, start_evt, phase_done, hold;
  logic       evt_key, evt_scan, evt_nokey, row_hit, evt_wake;
  logic [3:0] phase_code, events;

  assign core_clr  = swrst_i || !en_i;
  assign start_evt = start_i || (en_i && !en_q && autostart_i);
  assign hold      = core_clr || (state == ST_IDLE);
  assign running_o = (state != ST_IDLE);
  assign evt_wake  = (state == ST_IDLE) && row_hit;

  always_comb begin
    events           = '0;
    events[FL_NOKEY] = evt_nokey;
    events[FL_KEY]   = evt_key;
    events[FL_SCAN]  = evt_scan;
    events[FL_WAKE]  = evt_wake;
  end

  always_comb begin
    case (state)
      ST_SETTLE: phase_code = settle_code_i;
      ST_DEBNC:  phase_code = deb_code_i;
      default:   phase_code = gap_code_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      resetting_o <= 1'b0;
    end else begin
      en_q        <= en_i;
      resetting_o <= swrst_i;
    end
  end

  kpd_timer #(.DIVW(DIVW)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .div_i(clkdiv_i),
    .code_i(phase_code), .done_o(phase_done)
  );

  kpd_engine #(.NCOLS(NCOLS), .CW(CW)) u_engine (
    .clk(clk), .rst_n(rst_n), .clr_i(core_clr), .start_i(start_evt),
    .stop_i(stop_i), .phase_done_i(phase_done), .rows_i(rows_i),
    .nrows_code_i(nrows_code_i), .cols_n_o(cols_n_o), .state_o(state),
    .evt_key_o(evt_key), .evt_scan_o(evt_scan), .evt_nokey_o(evt_nokey),
    .row_hit_o(row_hit), .row_st_o(row_st_o), .col_st_o(col_st_o),
    .nokey_st_o(nokey_st_o)
  );

  kpd_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clr_core_i(core_clr), .single_i(single_i),
    .ev_i(events), .w1c_i(flag_clr_i), .ie_i(ie_i), .flags_o(flags_o),
    .irq_o(irq_o)
  );

  // R12
  resetting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_i |=> resetting_o);
  // R5
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !running_o);
  // R10
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && en_i && !swrst_i && !start_evt && (row_hits(rows_i, nrows_code_i) != '0))
      |=> flags_o[FL_WAKE]);
endmodule

// File: tb/sim_kpd_scan_ctrl.sv
module sim_kpd_scan_ctrl;
  localparam int NC = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, en, swrst, start, stop, autostart, single;
  logic [17:0] clkdiv;
  logic [3:0] settle_c, deb_c, gap_c, ie, wclr;
  logic [2:0] nrows_c;
  logic [5:0] rows;
  logic [NC-1:0] cols_n;
  logic running, resetting, nokey_st, irq;
  logic [5:0] row_st;
  logic [2:0] col_st;
  logic [3:0] flags;

  logic [5:0] keys [NC];
  logic [5:0] force_low;

  kpd_scan_ctrl #(.NCOLS(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .swrst_i(swrst), .start_i(start),
    .stop_i(stop), .autostart_i(autostart), .single_i(single),
    .clkdiv_i(clkdiv), .settle_code_i(settle_c), .deb_code_i(deb_c),
    .gap_code_i(gap_c), .nrows_code_i(nrows_c), .ie_i(ie),
    .flag_clr_i(wclr), .rows_i(rows), .cols_n_o(cols_n), .running_o(running),
    .resetting_o(resetting), .row_st_o(row_st), .col_st_o(col_st),
    .nokey_st_o(nokey_st), .flags_o(flags), .irq_o(irq)
  );

  // keypad: a held key pulls its row low while its column is driven low
  always_comb begin
    for (int r = 0; r < 6; r++) begin
      logic low;
      low = force_low[r];
      for (int c = 0; c < NC; c++) if (!cols_n[c] && keys[c][r]) low = 1'b1;
      rows[r] = !low;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model: 0 idle, 1 settle, 2 debounce, 3 gap
  int m_st, m_col, m_cyc, m_colst;
  logic [5:0] m_pat, m_row;
  logic [3:0] m_fl;
  bit m_kf, m_nk, m_arm, m_enq, m_res;

  function automatic int rows_in_use(input logic [2:0] code);
    int n;
    n = (code < 2) ? 3 : int'(code) + 1;
    return (n > 6) ? 6 : n;
  endfunction

  task automatic model_reset();
    m_st = 0; m_col = 0; m_cyc = 0; m_colst = 0; m_pat = 0; m_row = 0;
    m_fl = 0; m_kf = 0; m_nk = 0; m_arm = 1;
  endtask

  task automatic model_step();
    logic [5:0] hit;
    bit ek, es, enk, ew, ks, go, adv;
    int len, code;
    if (!rst_n) begin
      model_reset(); m_enq = 0; m_res = 0; return;
    end
    m_res = swrst;
    if (swrst || !en) begin
      model_reset(); m_enq = en; return;
    end
    hit = 0;
    for (int r = 0; r < rows_in_use(nrows_c); r++) hit[r] = !rows[r];
    ek = 0; es = 0; enk = 0; adv = 0;
    ew = (m_st == 0) && (hit != 0);
    go = start || (en && !m_enq && autostart);
    m_enq = en;
    if (stop) begin
      m_st = 0; m_col = 0; m_kf = 0; m_cyc = 0;
    end else if (m_st == 0) begin
      if (go) begin m_st = 1; m_col = 0; m_cyc = 0; end
    end else begin
      code = (m_st == 1) ? int'(settle_c) : (m_st == 2) ? int'(deb_c) : int'(gap_c);
      len = 2 * (code + 1) * (int'(clkdiv) + 1);
      if (m_cyc != len - 1) m_cyc++;
      else begin
        m_cyc = 0;
        if (m_st == 1) begin
          if (hit != 0) begin m_pat = hit; m_st = 2; end else adv = 1;
        end else if (m_st == 2) begin
          if (hit == m_pat) begin ek = 1; m_row = hit; m_colst = m_col; end
          adv = 1;
        end else begin
          m_st = 1; m_col = 0; m_kf = 0;
        end
        if (adv) begin
          if (m_col == NC - 1) begin
            es = 1; enk = !(m_kf || ek); m_nk = enk; m_st = 3;
          end else begin
            m_col++; m_st = 1;
          end
        end
        if (ek) m_kf = 1;
      end
    end
    ks = ek && (!single || m_arm);
    m_fl = (m_fl & ~wclr) | {ew, es, ks, enk};
    if (ks) m_arm = 0;
    else if (enk) m_arm = 1;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [NC-1:0] ec;
      ec = '1;
      if (m_st == 1 || m_st == 2) ec[m_col] = 1'b0;
      chk(cols_n == ec, "R3 column drive", int'(cols_n), int'(ec));
      chk(running == (m_st != 0), "R5 running", int'(running), int'(m_st != 0));
      chk(row_st == m_row && int'(col_st) == m_colst, "R4 key status",
          int'({row_st, col_st}), int'({m_row, 3'(m_colst)}));
      chk(nokey_st == m_nk, "R9 no-key status", int'(nokey_st), int'(m_nk));
      chk(flags == m_fl, "R11 flags", int'(flags), int'(m_fl));
      chk(irq == |(m_fl & ie), "R11 irq", int'(irq), int'(|(m_fl & ie)));
      chk(resetting == m_res, "R12 resetting", int'(resetting), int'(m_res));
    end
    model_step();
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_start(); start = 1; cyc(1); start = 0; endtask
  task automatic pulse_stop();  stop = 1;  cyc(1); stop = 0;  endtask
  task automatic pulse_clr(input logic [3:0] m); wclr = m; cyc(1); wclr = 0; endtask
  task automatic clear_keys(); for (int c = 0; c < NC; c++) keys[c] = 0; endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    model_reset(); m_enq = 0; m_res = 0;
    rst_n = 0; en = 0; swrst = 0; start = 0; stop = 0; autostart = 0; single = 0;
    clkdiv = 1; settle_c = 0; deb_c = 0; gap_c = 0; nrows_c = 5; ie = 0; wclr = 0;
    force_low = 0; clear_keys();
    cyc(3);
    chk(cols_n == '1, "R3 reset cols", int'(cols_n), 'hff);
    chk(running == 0 && flags == 0, "R5 reset state", int'({running, flags}), 0);
    rst_n = 1; cyc(2);

    en = 1; cyc(3);
    chk(running == 0, "R6 no autostart", int'(running), 0);

    // R1: settle code 2, divider 2 -> 2*3*3 = 18 clocks on column 0
    settle_c = 2; clkdiv = 2;
    pulse_start();
    n = 0;
    while (cols_n == 8'hfe && n < 1000) begin n++; cyc(1); end
    chk(n == 18, "R1 settle length", n, 18);
    pulse_stop();
    chk(running == 0, "R5 stop", int'(running), 0);
    settle_c = 0; clkdiv = 1; cyc(1);

    // R4/R8: multi-press, key at column 2 row 1
    keys[2] = 6'b000010;
    pulse_start(); cyc(100);
    chk(flags[1] == 1, "R4 key flag", int'(flags[1]), 1);
    chk(row_st == 6'b000010 && col_st == 2, "R4 key position", int'({row_st, col_st}), 'h12);
    pulse_clr(4'b0010); cyc(60);
    chk(flags[1] == 1, "R8 repeat while held", int'(flags[1]), 1);

    // R7: single-press lock until a no-key scan
    single = 1; pulse_clr(4'hf); cyc(100);
    chk(flags[1] == 0, "R7 locked", int'(flags[1]), 0);
    clear_keys(); cyc(60);
    chk(flags[0] == 1 && nokey_st == 1, "R9 no-key scan", int'({flags[0], nokey_st}), 3);
    keys[5] = 6'b000001; cyc(60);
    chk(flags[1] == 1 && col_st == 5, "R7 rearmed", int'({flags[1], col_st}), 'hd);

    // R2: row count clamp
    clear_keys(); single = 0; nrows_c = 0; keys[3] = 6'b001000;
    pulse_clr(4'hf); cyc(60);
    chk(flags[1] == 0 && flags[0] == 1, "R2 row 3 ignored", int'(flags[1:0]), 1);
    nrows_c = 3; pulse_clr(4'hf); cyc(60);
    chk(flags[1] == 1 && row_st == 6'b001000, "R2 four rows", int'({flags[1], row_st}), 'h48);

    // R10/R11: wake-up while idle, clear collides with set
    clear_keys(); pulse_stop(); nrows_c = 5;
    pulse_clr(4'hf); ie = 4'b1000; cyc(1);
    chk(irq == 0, "R11 irq low", int'(irq), 0);
    force_low = 6'b010000; cyc(2);
    chk(flags[3] == 1 && irq == 1, "R10 wake", int'({flags[3], irq}), 3);
    pulse_clr(4'b1000);
    chk(flags[3] == 1, "R11 set wins over clear", int'(flags[3]), 1);
    force_low = 0; cyc(1); pulse_clr(4'b1000);
    chk(flags[3] == 0 && irq == 0, "R11 cleared", int'({flags[3], irq}), 0);

    // R12: software reset
    force_low = 6'b000001; cyc(2); force_low = 0;
    swrst = 1; cyc(1); swrst = 0;
    chk(resetting == 1 && flags == 0, "R12 reset pulse", int'({resetting, flags}), 'h10);
    cyc(1);
    chk(resetting == 0, "R12 one cycle", int'(resetting), 0);

    // R6: enable with autostart, then disable mid-scan
    autostart = 1; en = 0; cyc(2);
    chk(running == 0, "R6 disabled", int'(running), 0);
    en = 1; cyc(1);
    chk(running == 1, "R6 autostart", int'(running), 1);
    cyc(10); en = 0; cyc(1);
    chk(running == 0 && cols_n == '1, "R6 disable resets", int'({running, cols_n}), 'hff);
    cyc(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule